// File: doc/BRIEF.md
# PID-Tagged Variable-Page Address Translator

This block is a small fully associative translation look-aside buffer. It turns a 32-bit effective address into a 32-bit physical address. Every lookup is tagged with an 8-bit process identifier. The key that is matched joins that identifier with the effective page number. Each entry carries its own page-size code, so the boundary between translated page bits and untranslated offset bits moves from entry to entry. Offset bits below that boundary pass straight through to the physical address. The bits above the boundary come from the matching entry's real page number.

Software loads entries through an index/write-enable port. The block holds no page table and does not walk one: only the resident entries are searched. When translation is disabled, the block runs in real mode and the effective address passes through untouched. The effective address, process identifier and enable are registered on each rising edge. The lookup is then combinational from those registered values, so a result appears one cycle after its inputs are presented.

Top module: `tlbx_translator`

## Requirements
- R1: With the captured translation enable low, `pa_o` equals the captured effective address, and `hit_o` and `miss_o` are both 0.
- R2: An entry matches only if all of the following hold: its valid bit is 1, its PID tag equals the captured process identifier, and its page tag equals the effective address in every bit at or above the entry's page boundary.
- R3: Page-size code c (0..7) selects a page of 2^(10+2c) bytes (1 KB, 4 KB, 16 KB, 64 KB, 256 KB, 1 MB, 4 MB, 16 MB). The effective-address bits below bit 10+2c are copied unchanged into `pa_o` on a hit.
- R4: On a hit, the bits of `pa_o` at and above the page boundary come from the entry's real page number, which is stored as physical-address bits [31:10]. Real-page-number bits below the boundary are ignored.
- R5: Page-tag bits below the entry's page boundary take no part in the compare. The page tag is stored as effective-address bits [31:10].
- R6: When several entries match, the entry with the lowest index supplies the physical address.
- R7: In translation mode with no matching entry, `miss_o` is 1, `hit_o` is 0 and `pa_o` is 0.
- R8: An entry written with `wr_en_i` high at a rising edge is used by the lookup whose inputs were captured at that same edge. This holds for loading a valid entry and for invalidating one.
- R9: Synchronous reset clears every entry's valid bit and the captured inputs. After reset the outputs are all zero, and translated lookups miss until entries are written again.
- R10: The outputs depend only on inputs captured at the most recent rising edge. A change on `ea_i` between edges does not reach `pa_o`.
- R11: `hit_o` and `miss_o` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ea_i | input | 32 | Effective address to translate |
| pid_i | input | 8 | Current process identifier |
| xlate_en_i | input | 1 | 1 = translate, 0 = real-mode pass-through |
| wr_en_i | input | 1 | Entry write strobe |
| wr_idx_i | input | 3 | Entry index to write |
| wr_valid_i | input | 1 | Valid bit for the written entry |
| wr_pid_i | input | 8 | PID tag for the written entry |
| wr_epn_i | input | 22 | Page tag (effective address bits [31:10]) |
| wr_size_i | input | 3 | Page-size code |
| wr_rpn_i | input | 22 | Real page number (physical address bits [31:10]) |
| pa_o | output | 32 | Physical address |
| hit_o | output | 1 | A valid entry matched in translation mode |
| miss_o | output | 1 | No entry matched in translation mode |

## Verification
The bench builds the block with its default parameters: eight entries, a 1 KB minimum page and a 3-bit size code that steps the page boundary by two bits. These defaults let one short run reach both the smallest page (1 KB, boundary at bit 10) and the largest (16 MB, boundary at bit 24). With tag and real-page-number bits set below the boundary, the run shows that those bits are ignored. Two entries overlap with different page sizes, which exposes the lowest-index rule. One page is matched on only one side of its upper edge, which exposes the compare boundary.

// File: rtl/tlbx_pkg.sv
package tlbx_pkg;

    parameter int unsigned TLBX_AW        = 32;
    parameter int unsigned TLBX_PID_W     = 8;
    parameter int unsigned TLBX_ENTRIES   = 8;
    parameter int unsigned TLBX_SIZE_W    = 3;
    parameter int unsigned TLBX_MIN_SHIFT = 10;
    parameter int unsigned TLBX_STEP      = 2;

    // Number of untranslated offset bits for a page-size code.
    function automatic int unsigned page_shift(input int unsigned code,
                                               input int unsigned min_shift,
                                               input int unsigned step);
        return min_shift + step * code;
    endfunction

endpackage

// File: rtl/tlbx_cmp.sv
module tlbx_cmp #(
    parameter int unsigned AW        = tlbx_pkg::TLBX_AW,
    parameter int unsigned PID_W     = tlbx_pkg::TLBX_PID_W,
    parameter int unsigned SIZE_W    = tlbx_pkg::TLBX_SIZE_W,
    parameter int unsigned MIN_SHIFT = tlbx_pkg::TLBX_MIN_SHIFT,
    parameter int unsigned STEP      = tlbx_pkg::TLBX_STEP
) (
    input  logic                    ent_valid_i,
    input  logic [PID_W-1:0]        ent_pid_i,
    input  logic [AW-MIN_SHIFT-1:0] ent_epn_i,
    input  logic [SIZE_W-1:0]       ent_size_i,
    input  logic [AW-MIN_SHIFT-1:0] ent_rpn_i,
    input  logic [AW-1:0]           ea_i,
    input  logic [PID_W-1:0]        pid_i,
    output logic                    match_o,
    output logic [AW-1:0]           pa_o
);

    localparam int unsigned MAX_SHIFT = tlbx_pkg::page_shift((1 << SIZE_W) - 1, MIN_SHIFT, STEP);

    logic [AW-1:0] hi_mask;
    logic [AW-1:0] tag_base;
    logic [AW-1:0] rpn_base;

    always_comb begin
        hi_mask  = {AW{1'b1}} << tlbx_pkg::page_shift(int'(ent_size_i), MIN_SHIFT, STEP);
        tag_base = {ent_epn_i, {MIN_SHIFT{1'b0}}};
        rpn_base = {ent_rpn_i, {MIN_SHIFT{1'b0}}};
        match_o  = ent_valid_i
                && (ent_pid_i == pid_i)
                && (((ea_i ^ tag_base) & hi_mask) == '0);
        pa_o     = (rpn_base & hi_mask) | (ea_i & ~hi_mask);
    end

    initial begin
        if (MAX_SHIFT >= AW) $error("largest page exceeds the address width");
    end

endmodule

// File: rtl/tlbx_pick.sv
module tlbx_pick #(
    parameter int unsigned N = tlbx_pkg::TLBX_ENTRIES
) (
    input  logic [N-1:0] req_i,
    output logic [N-1:0] sel_o,
    output logic         any_o
);

    logic [N:0] blocked;

    assign blocked[0] = 1'b0;

    for (genvar i = 0; i < N; i++) begin : g_chain
        assign sel_o[i]       = req_i[i] & ~blocked[i];
        assign blocked[i + 1] = blocked[i] | req_i[i];
    end

    assign any_o = blocked[N];

endmodule

// File: rtl/tlbx_translator.sv
module tlbx_translator #(
    parameter int unsigned AW        = tlbx_pkg::TLBX_AW,
    parameter int unsigned PID_W     = tlbx_pkg::TLBX_PID_W,
    parameter int unsigned ENTRIES   = tlbx_pkg::TLBX_ENTRIES,
    parameter int unsigned SIZE_W    = tlbx_pkg::TLBX_SIZE_W,
    parameter int unsigned MIN_SHIFT = tlbx_pkg::TLBX_MIN_SHIFT,
    parameter int unsigned STEP      = tlbx_pkg::TLBX_STEP
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [AW-1:0]               ea_i,
    input  logic [PID_W-1:0]            pid_i,
    input  logic                        xlate_en_i,
    input  logic                        wr_en_i,
    input  logic [$clog2(ENTRIES)-1:0]  wr_idx_i,
    input  logic                        wr_valid_i,
    input  logic [PID_W-1:0]            wr_pid_i,
    input  logic [AW-MIN_SHIFT-1:0]     wr_epn_i,
    input  logic [SIZE_W-1:0]           wr_size_i,
    input  logic [AW-MIN_SHIFT-1:0]     wr_rpn_i,
    output logic [AW-1:0]               pa_o,
    output logic                        hit_o,
    output logic                        miss_o
);

    localparam int unsigned TAG_W = AW - MIN_SHIFT;

    typedef struct packed {
        logic              valid;
        logic [PID_W-1:0]  pid;
        logic [TAG_W-1:0]  epn;
        logic [SIZE_W-1:0] size;
        logic [TAG_W-1:0]  rpn;
    } entry_t;

    typedef struct packed {
        entry_t [ENTRIES-1:0] tbl;
        logic [AW-1:0]        ea;
        logic [PID_W-1:0]     pid;
        logic                 en;
    } state_t;

    state_t st_d, st_q;

    // next-state process
    always_comb begin
        st_d     = st_q;
        st_d.ea  = ea_i;
        st_d.pid = pid_i;
        st_d.en  = xlate_en_i;
        if (wr_en_i) begin
            st_d.tbl[wr_idx_i].valid = wr_valid_i;
            st_d.tbl[wr_idx_i].pid   = wr_pid_i;
            st_d.tbl[wr_idx_i].epn   = wr_epn_i;
            st_d.tbl[wr_idx_i].size  = wr_size_i;
            st_d.tbl[wr_idx_i].rpn   = wr_rpn_i;
        end
        if (rst) begin
            for (int i = 0; i < int'(ENTRIES); i++) begin
                st_d.tbl[i].valid = 1'b0;
            end
            st_d.ea  = '0;
            st_d.pid = '0;
            st_d.en  = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    // parallel compare
    logic [ENTRIES-1:0] match;
    logic [ENTRIES-1:0] sel;
    logic               any_hit;
    logic [AW-1:0]      cand [ENTRIES];

    for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
        tlbx_cmp #(
            .AW        (AW),
            .PID_W     (PID_W),
            .SIZE_W    (SIZE_W),
            .MIN_SHIFT (MIN_SHIFT),
            .STEP      (STEP)
        ) u_cmp (
            .ent_valid_i (st_q.tbl[i].valid),
            .ent_pid_i   (st_q.tbl[i].pid),
            .ent_epn_i   (st_q.tbl[i].epn),
            .ent_size_i  (st_q.tbl[i].size),
            .ent_rpn_i   (st_q.tbl[i].rpn),
            .ea_i        (st_q.ea),
            .pid_i       (st_q.pid),
            .match_o     (match[i]),
            .pa_o        (cand[i])
        );
    end

    tlbx_pick #(.N(ENTRIES)) u_pick (
        .req_i (match),
        .sel_o (sel),
        .any_o (any_hit)
    );

    logic [AW-1:0] sel_pa;

    always_comb begin
        sel_pa = '0;
        for (int i = 0; i < int'(ENTRIES); i++) begin
            if (sel[i]) sel_pa = sel_pa | cand[i];
        end
    end

    // output selection
    always_comb begin
        pa_o   = '0;
        hit_o  = 1'b0;
        miss_o = 1'b0;
        if (!st_q.en) begin
            pa_o = st_q.ea;
        end else if (any_hit) begin
            pa_o  = sel_pa;
            hit_o = 1'b1;
        end else begin
            miss_o = 1'b1;
        end
    end

endmodule

// File: rtl/tlbx_checker.sv
module tlbx_checker #(
    parameter int unsigned AW = tlbx_pkg::TLBX_AW
) (
    input logic          clk,
    input logic          rst,
    input logic [AW-1:0] ea_i,
    input logic          xlate_en_i,
    input logic [AW-1:0] pa_o,
    input logic          hit_o,
    input logic          miss_o
);

    logic running_q = 1'b0;

    always_ff @(posedge clk) begin
        running_q <= !rst;
    end

    // R11
    hit_miss_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(hit_o && miss_o));

    // R1
    real_mode_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (running_q && !$past(xlate_en_i)) |-> (pa_o == $past(ea_i) && !hit_o && !miss_o));

    // R7
    miss_zero_pa_chk: assert property (@(posedge clk) disable iff (rst)
        miss_o |-> (pa_o == '0));

    // R9
    post_reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!hit_o && !miss_o && pa_o == '0));

    // R2
    hit_needs_xlate_chk: assert property (@(posedge clk) disable iff (rst)
        (running_q && hit_o) |-> $past(xlate_en_i));

endmodule

bind tlbx_translator tlbx_checker #(.AW(AW)) u_tlbx_chk (
    .clk        (clk),
    .rst        (rst),
    .ea_i       (ea_i),
    .xlate_en_i (xlate_en_i),
    .pa_o       (pa_o),
    .hit_o      (hit_o),
    .miss_o     (miss_o)
);

// File: tb/test_tlbx_translator.sv
module test_tlbx_translator;

    logic        clk = 1'b0;
    logic        rst;
    logic [31:0] ea_i;
    logic [7:0]  pid_i;
    logic        xlate_en_i;
    logic        wr_en_i;
    logic [2:0]  wr_idx_i;
    logic        wr_valid_i;
    logic [7:0]  wr_pid_i;
    logic [21:0] wr_epn_i;
    logic [2:0]  wr_size_i;
    logic [21:0] wr_rpn_i;
    logic [31:0] pa_o;
    logic        hit_o;
    logic        miss_o;

    int n_chk  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    tlbx_translator i_tlbx_translator (
        .clk, .rst, .ea_i, .pid_i, .xlate_en_i,
        .wr_en_i, .wr_idx_i, .wr_valid_i, .wr_pid_i, .wr_epn_i, .wr_size_i, .wr_rpn_i,
        .pa_o, .hit_o, .miss_o
    );

    // {en, pid, ea, exp_pa, exp_hit, exp_miss, req}
    localparam int NV = 14;
    localparam logic [78:0] VEC [NV] = '{
        {1'b0, 8'h00, 32'h12345678, 32'h12345678, 1'b0, 1'b0, 4'd1},  // R1
        {1'b1, 8'h11, 32'h12345678, 32'hABCDE678, 1'b1, 1'b0, 4'd5},  // R5 R4 tag/rpn low bits set
        {1'b1, 8'h11, 32'h12345FFF, 32'hABCDEFFF, 1'b1, 1'b0, 4'd3},  // R3 4 KB top offset
        {1'b1, 8'h11, 32'h12346000, 32'h00000000, 1'b0, 1'b1, 4'd7},  // R7 next page
        {1'b1, 8'h12, 32'h12345678, 32'h00000000, 1'b0, 1'b1, 4'd2},  // R2 pid differs
        {1'b1, 8'h22, 32'h0040BEEF, 32'h8000BEEF, 1'b1, 1'b0, 4'd3},  // R3 64 KB
        {1'b1, 8'h22, 32'h00410000, 32'h00000000, 1'b0, 1'b1, 4'd2},  // R2 bit 16 differs
        {1'b1, 8'h33, 32'hFFFFFDFF, 32'h000015FF, 1'b1, 1'b0, 4'd3},  // R3 1 KB
        {1'b1, 8'h33, 32'hFFFFF9FF, 32'h00000000, 1'b0, 1'b1, 4'd2},  // R2 bit 10 differs
        {1'b1, 8'h44, 32'h7FABCDEF, 32'h05ABCDEF, 1'b1, 1'b0, 4'd4},  // R4 16 MB
        {1'b1, 8'h55, 32'h20001234, 32'h30001234, 1'b1, 1'b0, 4'd6},  // R6 two match
        {1'b1, 8'h55, 32'h20030000, 32'h40030000, 1'b1, 1'b0, 4'd6},  // R6 only larger page
        {1'b1, 8'h66, 32'h60000010, 32'h00000000, 1'b0, 1'b1, 4'd2},  // R2 invalid entry
        {1'b0, 8'h66, 32'h60000010, 32'h60000010, 1'b0, 1'b0, 4'd1}   // R1
    };

    task automatic expect_out(input string req, input logic [31:0] e_pa,
                              input logic e_hit, input logic e_miss);
        n_chk++;
        if (pa_o !== e_pa || hit_o !== e_hit || miss_o !== e_miss) begin
            n_fail++;
            $display("FAIL %s: actual pa=%h hit=%b miss=%b expected pa=%h hit=%b miss=%b",
                     req, pa_o, hit_o, miss_o, e_pa, e_hit, e_miss);
        end
    endtask

    task automatic load(input logic [2:0] idx, input logic v, input logic [7:0] pid,
                        input logic [21:0] epn, input logic [2:0] sz, input logic [21:0] rpn);
        @(negedge clk);
        wr_en_i = 1'b1; wr_idx_i = idx; wr_valid_i = v; wr_pid_i = pid;
        wr_epn_i = epn; wr_size_i = sz; wr_rpn_i = rpn;
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    task automatic look(input logic en, input logic [7:0] pid, input logic [31:0] ea);
        xlate_en_i = en; pid_i = pid; ea_i = ea;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog (all requirements): actual still running, expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1; ea_i = '0; pid_i = '0; xlate_en_i = 1'b0;
        wr_en_i = 1'b0; wr_idx_i = '0; wr_valid_i = 1'b0; wr_pid_i = '0;
        wr_epn_i = '0; wr_size_i = '0; wr_rpn_i = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        expect_out("R9 reset state", 32'h0, 1'b0, 1'b0);

        load(3'd0, 1'b1, 8'h11, 22'h048D17, 3'd1, 22'h2AF37B);
        load(3'd1, 1'b1, 8'h22, 22'h001000, 3'd3, 22'h200000);
        load(3'd2, 1'b1, 8'h33, 22'h3FFFFF, 3'd0, 22'h000005);
        load(3'd3, 1'b1, 8'h44, 22'h1FFFFF, 3'd7, 22'h017FFF);
        load(3'd4, 1'b1, 8'h55, 22'h080000, 3'd2, 22'h0C0000);
        load(3'd5, 1'b1, 8'h55, 22'h080000, 3'd4, 22'h100000);
        load(3'd6, 1'b0, 8'h66, 22'h180000, 3'd1, 22'h000000);

        for (int i = 0; i < NV; i++) begin
            look(VEC[i][78], VEC[i][77:70], VEC[i][69:38]);
            @(negedge clk);
            expect_out($sformatf("R%0d vector %0d", VEC[i][3:0], i),
                       VEC[i][37:6], VEC[i][5], VEC[i][4]);
        end

        // R8: empty slot misses, then write and lookup share one edge
        look(1'b1, 8'h77, 32'h90000ABC);
        @(negedge clk);
        expect_out("R8 before write", 32'h0, 1'b0, 1'b1);
        wr_en_i = 1'b1; wr_idx_i = 3'd7; wr_valid_i = 1'b1; wr_pid_i = 8'h77;
        wr_epn_i = 22'h240000; wr_size_i = 3'd1; wr_rpn_i = 22'h280000;
        @(negedge clk);
        wr_en_i = 1'b0;
        expect_out("R8 same-edge write", 32'hA0000ABC, 1'b1, 1'b0);
        wr_en_i = 1'b1; wr_valid_i = 1'b0;
        @(negedge clk);
        wr_en_i = 1'b0;
        expect_out("R8 same-edge invalidate", 32'h0, 1'b0, 1'b1);

        // R10: input change between edges does not reach output
        look(1'b0, 8'h00, 32'h11111111);
        @(negedge clk);
        expect_out("R10 capture", 32'h11111111, 1'b0, 1'b0);
        look(1'b0, 8'h00, 32'h22222222);
        #2;
        expect_out("R10 between edges", 32'h11111111, 1'b0, 1'b0);
        @(negedge clk);
        expect_out("R10 next edge", 32'h22222222, 1'b0, 1'b0);

        // R9: reset drops all entries
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        expect_out("R9 after second reset", 32'h0, 1'b0, 1'b0);
        look(1'b1, 8'h11, 32'h12345678);
        @(negedge clk);
        expect_out("R9 entry cleared", 32'h0, 1'b0, 1'b1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule